// File: doc/BRIEF.md
# Resistive Touch Scan Sequencer

This block runs the measurement loop of a four-wire resistive touch panel without software involvement. It owns a 16-bit panel control word that selects which plate terminals are powered or grounded, the panel mode and the bias. It asks an external ADC controller for conversions through a start/done handshake with a channel select. Each pass takes X position, then Y position, then pressure. It then puts the panel back into pen-detect mode, waits a poll interval and reads the two plate-low flags to decide whether the pen is still down.

With the pen down, the sequencer emits one sample event that carries x, y and pressure, and it starts the next pass after another poll interval. With the pen up, it arms the pen interrupt and goes idle until `start_i` arrives. If the previous pass sent a sample, it first emits a single release event. A stop request lets an ADC conversion in progress finish, clears the panel word, emits a release if a sample is still active, and returns the block to idle. All settle and poll times are parameters counted in clock cycles.

Top module: `tsq_scan_seq`

## Requirements
- R1: While reset is asserted, `panel_word_o` is 0 and `panel_wr_o`, `adc_en_o`, `adc_start_o`, `pen_irq_en_o` and `evt_valid_o` are low.
- R2: A pass started by `start_i` issues, in this order: three X writes, a conversion on channel 2 (+Y input), three Y writes, a conversion on channel 0 (+X input), one pressure write, a conversion on channel 2, and one pen-detect write.
- R3: Panel word encodings, using power bits 0..3 (-X,+X,-Y,+Y), ground bits 4..7 (same order), mode in bits 9:8 (0 detect, 1 pressure, 2 position) and bias in bit 11. X setup is 0x0912 written twice, then X position 0x0A12. Y setup is 0x0948 written twice, then Y position 0x0A48. Pressure is 0x09C3, pen-detect is 0x00C3 and stopped is 0x0000.
- R4: After each position-mode write, at least SETTLE_POS_CYC+1 cycles pass before the conversion start strobe.
- R5: After the pressure write, at least SETTLE_PRES_CYC+1 cycles pass before the conversion start strobe.
- R6: `adc_en_o` is high at every conversion start and low when the pen-detect word is written.
- R7: If both plate-low flags read 0 after the poll interval, the block emits a sample event whose x, y and pressure equal the three conversion results of the pass, in order. It then starts a new pass without any further `start_i`.
- R8: If any plate-low flag reads 1, `pen_irq_en_o` rises and the block stays idle until `start_i`. It emits one release event only if the previous pass emitted a sample; otherwise it emits no event.
- R9: `stop_i` lets an ADC conversion in progress complete, then writes panel word 0 and drops `adc_en_o` and `pen_irq_en_o`. It emits a release event if a sample was still active, and then idles.
- R10: `evt_valid_o` is high for exactly one cycle per event, and a release event (`evt_release_o`=1) carries pressure 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pen interrupt or restart; begins a pass from idle |
| stop_i | input | 1 | Stop request pulse |
| plate_low_i | input | 2 | Plate-low flags read back from the panel |
| panel_word_o | output | 16 | Current panel control word |
| panel_wr_o | output | 1 | One-cycle strobe per panel word write |
| adc_en_o | output | 1 | ADC enable |
| adc_start_o | output | 1 | One-cycle conversion start |
| adc_ch_o | output | 3 | Conversion input select |
| adc_done_i | input | 1 | Conversion complete |
| adc_data_i | input | DW | Conversion result |
| pen_irq_en_o | output | 1 | Pen interrupt armed |
| evt_valid_o | output | 1 | Event strobe |
| evt_release_o | output | 1 | Event is a release |
| evt_x_o | output | DW | Sample x |
| evt_y_o | output | DW | Sample y |
| evt_p_o | output | DW | Sample pressure |

## Verification
A sequencer state that is wrong shows up at once as a panel write or a conversion start that is out of order or carries the wrong value. The scoreboard catches it at the first strobe that differs. A settle counter that ends too early shortens the gap between the position or pressure write and the next start strobe. That gap is measured on every conversion. A lost or stuck record of an active sample becomes visible only at the next pen-up or stop. It then shows as a missing release or an extra one, one poll interval later.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int PW = 16;
  localparam int B_PWR_MX = 0;
  localparam int B_PWR_PX = 1;
  localparam int B_PWR_MY = 2;
  localparam int B_PWR_PY = 3;
  localparam int B_GND_MX = 4;
  localparam int B_GND_PX = 5;
  localparam int B_GND_MY = 6;
  localparam int B_GND_PY = 7;
  localparam int MODE_LSB = 8;
  localparam int B_BIAS   = 11;

  localparam logic [1:0] MODE_DET  = 2'd0;
  localparam logic [1:0] MODE_PRES = 2'd1;
  localparam logic [1:0] MODE_POS  = 2'd2;

  localparam int CHW = 3;
  localparam logic [CHW-1:0] CH_PX = 3'd0;
  localparam logic [CHW-1:0] CH_PY = 3'd2;

  typedef enum logic [2:0] {
    WK_OFF, WK_X_SET, WK_X_POS, WK_Y_SET, WK_Y_POS, WK_PRESS, WK_DET
  } wkind_e;

  typedef enum logic [1:0] {PH_X, PH_Y, PH_P} phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ADC_ON, S_WR_A, S_WR_B, S_WR_C, S_SETTLE, S_CONV, S_WAIT,
    S_ADC_OFF, S_WR_DET, S_POLL, S_CHECK, S_HOLD, S_STOP
  } state_e;
endpackage

// File: rtl/tsq_word_sel.sv
module tsq_word_sel
  import tsq_pkg::*;
(
  input  wkind_e        kind_i,
  output logic [PW-1:0] word_o
);
  always_comb begin
    word_o = '0;
    unique case (kind_i)
      WK_X_SET, WK_X_POS: begin
        word_o[B_GND_MX] = 1'b1;
        word_o[B_PWR_PX] = 1'b1;
        word_o[B_BIAS]   = 1'b1;
        word_o[MODE_LSB +: 2] = (kind_i == WK_X_POS) ? MODE_POS : MODE_PRES;
      end
      WK_Y_SET, WK_Y_POS: begin
        word_o[B_GND_MY] = 1'b1;
        word_o[B_PWR_PY] = 1'b1;
        word_o[B_BIAS]   = 1'b1;
        word_o[MODE_LSB +: 2] = (kind_i == WK_Y_POS) ? MODE_POS : MODE_PRES;
      end
      WK_PRESS, WK_DET: begin
        word_o[B_PWR_MX] = 1'b1;
        word_o[B_PWR_PX] = 1'b1;
        word_o[B_GND_MY] = 1'b1;
        word_o[B_GND_PY] = 1'b1;
        word_o[B_BIAS]   = (kind_i == WK_PRESS);
        word_o[MODE_LSB +: 2] = (kind_i == WK_PRESS) ? MODE_PRES : MODE_DET;
      end
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/tsq_timer.sv
module tsq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_STAYS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0); // R4
  AST_TMR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(val_i)); // R5
endmodule

// File: rtl/tsq_capture.sv
module tsq_capture
  import tsq_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  phase_e        phase_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] p_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
      p_o <= '0;
    end else if (cap_i) begin
      unique case (phase_i)
        PH_X:    x_o <= data_i;
        PH_Y:    y_o <= data_i;
        default: p_o <= data_i;
      endcase
    end
  end
endmodule

// File: rtl/tsq_scan_seq.sv
module tsq_scan_seq
  import tsq_pkg::*;
#(
  parameter int DW              = 10,
  parameter int SETTLE_POS_CYC  = 5500,
  parameter int SETTLE_PRES_CYC = 0,
  parameter int POLL_CYC        = 1000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [1:0]    plate_low_i,
  output logic [15:0]   panel_word_o,
  output logic          panel_wr_o,
  output logic          adc_en_o,
  output logic          adc_start_o,
  output logic [2:0]    adc_ch_o,
  input  logic          adc_done_i,
  input  logic [DW-1:0] adc_data_i,
  output logic          pen_irq_en_o,
  output logic          evt_valid_o,
  output logic          evt_release_o,
  output logic [DW-1:0] evt_x_o,
  output logic [DW-1:0] evt_y_o,
  output logic [DW-1:0] evt_p_o
);
  localparam int MAX_A = (SETTLE_POS_CYC > SETTLE_PRES_CYC) ? SETTLE_POS_CYC : SETTLE_PRES_CYC;
  localparam int MAX_C = (MAX_A > POLL_CYC) ? MAX_A : POLL_CYC;
  localparam int CW    = $clog2(MAX_C + 1) + 1;
  localparam logic [CW-1:0] T_POS  = CW'(SETTLE_POS_CYC);
  localparam logic [CW-1:0] T_PRES = CW'(SETTLE_PRES_CYC);
  localparam logic [CW-1:0] T_POLL = CW'(POLL_CYC);

  state_e st_q, st_d;
  phase_e ph_q, ph_d;
  logic stop_pend_q, stop_req, stop_clr;
  logic active_q, act_d;
  logic en_d, irq_d, start_d, ev_d, rel_d;
  logic wr_en, tmr_load, tmr_zero, cap;
  logic [CW-1:0] tmr_val;
  wkind_e wr_kind;
  logic [PW-1:0] wr_word;
  logic [DW-1:0] cap_x, cap_y, cap_p;

  assign stop_req = stop_i | stop_pend_q;

  tsq_word_sel i_word_sel (.kind_i(wr_kind), .word_o(wr_word));

  tsq_timer #(.CW(CW)) i_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  tsq_capture #(.DW(DW)) i_capture (
    .clk_i, .rst_ni, .cap_i(cap), .phase_i(ph_q), .data_i(adc_data_i),
    .x_o(cap_x), .y_o(cap_y), .p_o(cap_p)
  );

  always_comb begin
    st_d = st_q; ph_d = ph_q;
    wr_en = 1'b0; wr_kind = WK_OFF;
    tmr_load = 1'b0; tmr_val = '0; cap = 1'b0;
    start_d = 1'b0; en_d = adc_en_o; irq_d = pen_irq_en_o;
    act_d = active_q; ev_d = 1'b0; rel_d = 1'b0; stop_clr = 1'b0;
    if (stop_req && st_q != S_WAIT && st_q != S_STOP) begin
      st_d = S_STOP;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) st_d = S_ADC_ON;
        S_ADC_ON: begin
          en_d = 1'b1; irq_d = 1'b0; ph_d = PH_X; st_d = S_WR_A;
        end
        S_WR_A: begin
          wr_en = 1'b1;
          if (ph_q == PH_P) begin
            wr_kind = WK_PRESS; tmr_load = 1'b1; tmr_val = T_PRES; st_d = S_SETTLE;
          end else begin
            wr_kind = (ph_q == PH_X) ? WK_X_SET : WK_Y_SET; st_d = S_WR_B;
          end
        end
        S_WR_B: begin
          wr_en = 1'b1; wr_kind = (ph_q == PH_X) ? WK_X_SET : WK_Y_SET; st_d = S_WR_C;
        end
        S_WR_C: begin
          wr_en = 1'b1; wr_kind = (ph_q == PH_X) ? WK_X_POS : WK_Y_POS;
          tmr_load = 1'b1; tmr_val = T_POS; st_d = S_SETTLE;
        end
        S_SETTLE: if (tmr_zero) st_d = S_CONV;
        S_CONV: begin
          start_d = 1'b1; st_d = S_WAIT;
        end
        S_WAIT: if (adc_done_i) begin
          cap = 1'b1;
          unique case (ph_q)
            PH_X:    begin ph_d = PH_Y; st_d = S_WR_A; end
            PH_Y:    begin ph_d = PH_P; st_d = S_WR_A; end
            default: st_d = S_ADC_OFF;
          endcase
        end
        S_ADC_OFF: begin
          en_d = 1'b0; st_d = S_WR_DET;
        end
        S_WR_DET: begin
          wr_en = 1'b1; wr_kind = WK_DET;
          tmr_load = 1'b1; tmr_val = T_POLL; st_d = S_POLL;
        end
        S_POLL: if (tmr_zero) st_d = S_CHECK;
        S_CHECK: begin
          if (|plate_low_i) begin
            ev_d = active_q; rel_d = active_q;
            act_d = 1'b0; irq_d = 1'b1; st_d = S_IDLE;
          end else begin
            ev_d = 1'b1; act_d = 1'b1;
            tmr_load = 1'b1; tmr_val = T_POLL; st_d = S_HOLD;
          end
        end
        S_HOLD: if (tmr_zero) st_d = S_ADC_ON;
        S_STOP: begin
          en_d = 1'b0; irq_d = 1'b0;
          wr_en = 1'b1; wr_kind = WK_OFF;
          ev_d = active_q; rel_d = active_q;
          act_d = 1'b0; stop_clr = 1'b1; st_d = S_IDLE;
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; ph_q <= PH_X;
      stop_pend_q <= 1'b0; active_q <= 1'b0;
      panel_word_o <= '0; panel_wr_o <= 1'b0;
      adc_en_o <= 1'b0; adc_start_o <= 1'b0; adc_ch_o <= '0;
      pen_irq_en_o <= 1'b0;
      evt_valid_o <= 1'b0; evt_release_o <= 1'b0;
      evt_x_o <= '0; evt_y_o <= '0; evt_p_o <= '0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; active_q <= act_d;
      if (stop_clr)    stop_pend_q <= 1'b0;
      else if (stop_i) stop_pend_q <= 1'b1;
      panel_wr_o <= wr_en;
      if (wr_en) panel_word_o <= wr_word;
      adc_en_o <= en_d;
      adc_start_o <= start_d;
      if (start_d) adc_ch_o <= (ph_q == PH_Y) ? CH_PX : CH_PY;
      pen_irq_en_o <= irq_d;
      evt_valid_o <= ev_d;
      evt_release_o <= rel_d;
      if (ev_d) begin
        evt_x_o <= rel_d ? '0 : cap_x;
        evt_y_o <= rel_d ? '0 : cap_y;
        evt_p_o <= rel_d ? '0 : cap_p;
      end
    end
  end

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o); // R10
  AST_REL_NO_PRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_release_o) |-> evt_p_o == '0); // R10
  AST_START_ADC_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> adc_en_o); // R6
  AST_CONV_BIASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> panel_word_o[B_BIAS]); // R3
  AST_DET_WORD_ADC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (panel_wr_o && panel_word_o == 16'h00C3) |-> !adc_en_o); // R6
  AST_ARMED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pen_irq_en_o |-> !adc_en_o); // R8
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (panel_wr_o && panel_word_o == '0) |-> (!adc_en_o && !pen_irq_en_o)); // R9
endmodule

// File: tb/test_tsq_scan_seq.sv
module test_tsq_scan_seq;
  localparam int DW = 10;
  localparam int SP = 6;
  localparam int SPR = 2;
  localparam int PL = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic start_i = 1'b0, stop_i = 1'b0;
  logic [1:0] plate_low_i = 2'b00;
  logic [15:0] panel_word_o;
  logic panel_wr_o, adc_en_o, adc_start_o;
  logic [2:0] adc_ch_o;
  logic adc_done_i = 1'b0;
  logic [DW-1:0] adc_data_i = '0;
  logic pen_irq_en_o, evt_valid_o, evt_release_o;
  logic [DW-1:0] evt_x_o, evt_y_o, evt_p_o;

  tsq_scan_seq #(.DW(DW), .SETTLE_POS_CYC(SP), .SETTLE_PRES_CYC(SPR), .POLL_CYC(PL))
  i_tsq_scan_seq (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .plate_low_i,
    .panel_word_o, .panel_wr_o, .adc_en_o, .adc_start_o, .adc_ch_o,
    .adc_done_i, .adc_data_i, .pen_irq_en_o,
    .evt_valid_o, .evt_release_o, .evt_x_o, .evt_y_o, .evt_p_o
  );

  typedef struct {int kind; int a; int b; int c;} item_t;
  item_t exp_q[$];
  int adc_q[$];
  int n_cmp = 0, n_bad = 0;
  int cyc = 0, last_wr_cyc = 0, last_word = 0;
  bit prev_evt = 1'b0, finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(int k, int a, int b, int c);
    item_t it;
    it.kind = k; it.a = a; it.b = b; it.c = c;
    exp_q.push_back(it);
  endtask

  // kinds: 0 panel write, 1 conversion start, 2 sample, 3 release
  task automatic push_pass(bit touch, bit was_active, int x, int y, int p);
    push(0, 'h0912, 0, 0); push(0, 'h0912, 0, 0); push(0, 'h0A12, 0, 0); push(1, 2, 0, 0);
    push(0, 'h0948, 0, 0); push(0, 'h0948, 0, 0); push(0, 'h0A48, 0, 0); push(1, 0, 0, 0);
    push(0, 'h09C3, 0, 0); push(1, 2, 0, 0);
    push(0, 'h00C3, 0, 0);
    if (touch) push(2, x, y, p);
    else if (was_active) push(3, 0, 0, 0);
    adc_q.push_back(x); adc_q.push_back(y); adc_q.push_back(p);
  endtask

  task automatic got(int k, int a, int b, int c);
    item_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R8", "unexpected item kind", k, -1);
      return;
    end
    e = exp_q.pop_front();
    case (e.kind)
      0: chk(k == 0 && a == e.a, "R3", "panel word", a, e.a);
      1: chk(k == 1 && a == e.a, "R2", "conversion channel", a, e.a);
      2: begin
        chk(k == 2, "R7", "event kind", k, 2);
        chk(a == e.a && b == e.b && c == e.c, "R7", "sample xyp", (a << 20) | (b << 10) | c,
            (e.a << 20) | (e.b << 10) | e.c);
      end
      default: begin
        chk(k == 3, "R8", "release event kind", k, 3);
        chk(c == 0, "R10", "release pressure", c, 0);
      end
    endcase
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (panel_wr_o) begin
        got(0, int'(panel_word_o), 0, 0);
        if (panel_word_o == 16'h00C3) chk(!adc_en_o, "R6", "adc_en at detect write", adc_en_o, 0);
        last_wr_cyc = cyc;
        last_word = int'(panel_word_o);
      end
      if (adc_start_o) begin
        got(1, int'(adc_ch_o), 0, 0);
        chk(adc_en_o, "R6", "adc_en at start", adc_en_o, 1);
        if (last_word == 'h09C3)
          chk(cyc - last_wr_cyc >= SPR + 1, "R5", "pressure settle gap", cyc - last_wr_cyc, SPR + 1);
        else
          chk(cyc - last_wr_cyc >= SP + 1, "R4", "position settle gap", cyc - last_wr_cyc, SP + 1);
      end
      if (evt_valid_o) begin
        if (prev_evt) chk(1'b0, "R10", "event strobe longer than one cycle", 1, 0);
        got(evt_release_o ? 3 : 2, int'(evt_x_o), int'(evt_y_o), int'(evt_p_o));
      end
      prev_evt = evt_valid_o;
    end
  end

  // ADC model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && adc_start_o) begin
        int v;
        v = (adc_q.size() != 0) ? adc_q.pop_front() : 0;
        repeat (3) @(negedge clk);
        adc_data_i = DW'(v);
        adc_done_i = 1'b1;
        @(negedge clk);
        adc_done_i = 1'b0;
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog expired actual=%0d expected=0", exp_q.size());
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(panel_word_o == 0, "R1", "reset panel word", panel_word_o, 0);
    chk(!panel_wr_o, "R1", "reset panel strobe", panel_wr_o, 0);
    chk(!adc_en_o && !adc_start_o, "R1", "reset adc controls", {adc_en_o, adc_start_o}, 0);
    chk(!pen_irq_en_o, "R1", "reset pen irq", pen_irq_en_o, 0);
    chk(!evt_valid_o, "R1", "reset event", evt_valid_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // touch, then automatic second pass with pen lifted
    plate_low_i = 2'b00;
    push_pass(1'b1, 1'b0, 'h123, 'h2AB, 'h050);
    pulse_start();
    drain();
    plate_low_i = 2'b10;
    push_pass(1'b0, 1'b1, 'h111, 'h222, 'h033);
    drain();
    repeat (3) @(negedge clk);
    chk(pen_irq_en_o, "R8", "pen irq armed after lift", pen_irq_en_o, 1);
    repeat (3 * PL) @(negedge clk);
    chk(!adc_en_o, "R8", "stays idle", adc_en_o, 0);

    // pen-up pass without previous sample: no event
    plate_low_i = 2'b01;
    push_pass(1'b0, 1'b0, 'h0AA, 'h155, 'h3FF);
    pulse_start();
    drain();
    repeat (3 * PL) @(negedge clk);
    chk(pen_irq_en_o, "R8", "pen irq armed, no release", pen_irq_en_o, 1);

    // stop during a conversion while a sample is active
    plate_low_i = 2'b00;
    push_pass(1'b1, 1'b0, 'h3FE, 'h001, 'h200);
    pulse_start();
    drain();
    push(0, 'h0912, 0, 0); push(0, 'h0912, 0, 0); push(0, 'h0A12, 0, 0); push(1, 2, 0, 0);
    push(0, 0, 0, 0); push(3, 0, 0, 0);
    adc_q.push_back('h077);
    @(negedge clk);
    while (!adc_start_o) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    drain();
    repeat (2) @(negedge clk);
    chk(panel_word_o == 0, "R9", "panel word after stop", panel_word_o, 0);
    chk(!adc_en_o && !pen_irq_en_o, "R9", "adc/irq after stop", {adc_en_o, pen_irq_en_o}, 0);
    repeat (3 * PL) @(negedge clk);

    // stop from idle with nothing active: clear word only
    push(0, 0, 0, 0);
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    drain();
    repeat (3 * PL) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "leftover expected items", exp_q.size(), 0);
    finish_run();
  end
endmodule